// File: doc/BRIEF.md
# Address Translation Fault Classifier

This block sits between a load, store or fetch unit and the result of a TLB lookup. For each access it makes one of three decisions. If translation is switched off, or no translation unit is fitted, the access passes straight through. If translation is on and the lookup hits, the block forms the physical address from the page mapping. If the lookup misses or reports a protection violation, the access is faulted. Each decision is registered, and its result appears one cycle after the request.

On a fault the block records the full virtual address and a syndrome code. It then sends a single-cycle fault request to the exception sequencer. The sequencer acknowledges the fault once it has been handled. If a second fault arrives while an earlier one is still unacknowledged, it is a recursive fault. The block reports it on a separate error pulse and leaves the recorded fault state untouched. TLB storage and replacement are outside this block.

Top module: `xlate_fault_unit`

## Requirements
- R1: While reset is asserted, and directly after it, `resp_valid`, `fault_req` and `recur_err` are 0, and `fault_addr` and `fault_code` are 0.
- R2: A valid request with `mmu_fitted`=0 or `xlate_en`=0 is passed through, whatever the TLB inputs are. One cycle later `resp_valid`=1, `resp_translated`=0, `resp_perm`=3'b111, and `resp_paddr` equals `req_vaddr` with the page-offset bits cleared (default page size 4096 bytes).
- R3: A valid request with `mmu_fitted`=1, `xlate_en`=1 and `tlb_hit`=1 gives, one cycle later, `resp_valid`=1, `resp_translated`=1, `resp_perm`=`tlb_perm`, and `resp_paddr` = `tlb_pbase` + page-aligned `req_vaddr` − `tlb_vbase`.
- R4: When a fault is accepted, `fault_addr` takes the complete unaligned `req_vaddr`.
- R5: For a protection fault (`tlb_hit`=0, `tlb_prot`=1), `fault_code[4:0]` is 17 when `req_type`=2 (fetch) and 16 for any other type.
- R6: For a miss (`tlb_hit`=0, `tlb_prot`=0), `fault_code[4:0]` is 19 when `req_type`=2 (fetch) and 18 for any other type.
- R7: `fault_code[10]` is 1 exactly when `req_type`=1 (store). All other `fault_code` bits are 0. `req_type` 0 is a load and 3 is treated as a load.
- R8: An accepted fault raises `fault_req` for exactly the one cycle after the request, with `resp_valid`=0.
- R9: `fault_addr` and `fault_code` hold their values until the next accepted fault.
- R10: A fault arriving while an earlier fault is still unacknowledged pulses `recur_err` for one cycle. `fault_req` stays 0, and `fault_addr` and `fault_code` keep their values. A fault stays pending from its acceptance until `fault_ack` is sampled high.
- R11: If `fault_ack` is high in the same cycle as a new fault, the pending fault is cleared and the new fault is accepted normally. No `recur_err` is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request present |
| req_type | input | 2 | 0 load, 1 store, 2 fetch, 3 treated as load |
| req_vaddr | input | VA_W | Virtual address of the access |
| mmu_fitted | input | 1 | Translation unit present in this configuration |
| xlate_en | input | 1 | Translation enable from the machine state |
| tlb_hit | input | 1 | Lookup found a valid mapping |
| tlb_prot | input | 1 | On a non-hit: 1 protection violation, 0 miss |
| tlb_vbase | input | VA_W | Virtual base of the matching entry |
| tlb_pbase | input | PA_W | Physical base of the matching entry |
| tlb_perm | input | PERM_W | Permissions of the matching entry |
| fault_ack | input | 1 | Sequencer has taken the pending fault |
| resp_valid | output | 1 | Translation or pass-through result valid |
| resp_paddr | output | PA_W | Physical page address |
| resp_perm | output | PERM_W | Granted permissions |
| resp_translated | output | 1 | Result came from a TLB mapping |
| fault_req | output | 1 | One-cycle fault request |
| fault_addr | output | VA_W | Captured faulting address |
| fault_code | output | CODE_W | Fault syndrome |
| recur_err | output | 1 | Recursive fault detected |

## Verification
Two functions can fall in the same cycle: a new fault request and the acknowledge that retires the previous fault. The bench creates this case by leaving one fault unacknowledged and then driving a fresh miss together with `fault_ack`. The scoreboard expects a clean `fault_req` carrying the new address and code, with no `recur_err`. The same fault driven without the acknowledge is expected to give only `recur_err`, with the captured address and code unchanged.

// File: rtl/xlate_fault_pkg.sv
package xlate_fault_pkg;

    localparam int unsigned CODE_PROT_DATA  = 16;
    localparam int unsigned CODE_PROT_FETCH = 17;
    localparam int unsigned CODE_MISS_DATA  = 18;
    localparam int unsigned CODE_MISS_FETCH = 19;
    localparam int unsigned STORE_BIT       = 10;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_type_e;

    typedef enum logic [2:0] {
        DEC_IDLE   = 3'd0,
        DEC_BYPASS = 3'd1,
        DEC_MAP    = 3'd2,
        DEC_MISS   = 3'd3,
        DEC_PROT   = 3'd4
    } decision_e;

endpackage

// File: rtl/xlate_fault_classify.sv
module xlate_fault_classify
    import xlate_fault_pkg::*;
(
    input  logic      req_valid,
    input  logic      mmu_fitted,
    input  logic      xlate_en,
    input  logic      tlb_hit,
    input  logic      tlb_prot,
    output decision_e decision
);
    always_comb begin
        if (!req_valid) begin
            decision = DEC_IDLE;
        end else if (!(mmu_fitted && xlate_en)) begin
            decision = DEC_BYPASS;
        end else if (tlb_hit) begin
            decision = DEC_MAP;
        end else if (tlb_prot) begin
            decision = DEC_PROT;
        end else begin
            decision = DEC_MISS;
        end
    end
endmodule

// File: rtl/xlate_fault_addr.sv
module xlate_fault_addr #(
    parameter int unsigned VA_W       = 32,
    parameter int unsigned PA_W       = 32,
    parameter int unsigned PAGE_BYTES = 4096
) (
    input  logic [VA_W-1:0] vaddr,
    input  logic [VA_W-1:0] vbase,
    input  logic [PA_W-1:0] pbase,
    output logic [PA_W-1:0] mapped_paddr,
    output logic [PA_W-1:0] bypass_paddr
);
    localparam int unsigned OFS_W = $clog2(PAGE_BYTES);
    localparam int unsigned SUM_W = (VA_W > PA_W) ? VA_W : PA_W;

    logic [VA_W-1:0]  page_va;
    logic [SUM_W-1:0] va_ext;
    logic [SUM_W-1:0] vb_ext;
    logic [SUM_W-1:0] pb_ext;
    logic [SUM_W-1:0] sum;

    assign page_va = {vaddr[VA_W-1:OFS_W], {OFS_W{1'b0}}};

    generate
        if (SUM_W > VA_W) begin : g_va_pad
            assign va_ext = {{(SUM_W-VA_W){1'b0}}, page_va};
            assign vb_ext = {{(SUM_W-VA_W){1'b0}}, vbase};
        end else begin : g_va_same
            assign va_ext = page_va;
            assign vb_ext = vbase;
        end
        if (SUM_W > PA_W) begin : g_pa_pad
            assign pb_ext = {{(SUM_W-PA_W){1'b0}}, pbase};
        end else begin : g_pa_same
            assign pb_ext = pbase;
        end
    endgenerate

    assign sum          = pb_ext + va_ext - vb_ext;
    assign mapped_paddr = sum[PA_W-1:0];
    assign bypass_paddr = va_ext[PA_W-1:0];
endmodule

// File: rtl/xlate_fault_code.sv
module xlate_fault_code
    import xlate_fault_pkg::*;
#(
    parameter int unsigned CODE_W = 16
) (
    input  logic              is_prot,
    input  logic [1:0]        acc_type,
    output logic [CODE_W-1:0] code
);
    logic is_fetch;
    logic is_store;

    assign is_fetch = (acc_type == ACC_FETCH);
    assign is_store = (acc_type == ACC_STORE);

    always_comb begin
        code = '0;
        if (is_prot) begin
            code[4:0] = is_fetch ? 5'(CODE_PROT_FETCH) : 5'(CODE_PROT_DATA);
        end else begin
            code[4:0] = is_fetch ? 5'(CODE_MISS_FETCH) : 5'(CODE_MISS_DATA);
        end
        code[STORE_BIT] = is_store;
    end
endmodule

// File: rtl/xlate_fault_unit.sv
module xlate_fault_unit
    import xlate_fault_pkg::*;
#(
    parameter int unsigned VA_W       = 32,
    parameter int unsigned PA_W       = 32,
    parameter int unsigned PERM_W     = 3,
    parameter int unsigned CODE_W     = 16,
    parameter int unsigned PAGE_BYTES = 4096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_type,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic              mmu_fitted,
    input  logic              xlate_en,
    input  logic              tlb_hit,
    input  logic              tlb_prot,
    input  logic [VA_W-1:0]   tlb_vbase,
    input  logic [PA_W-1:0]   tlb_pbase,
    input  logic [PERM_W-1:0] tlb_perm,
    input  logic              fault_ack,
    output logic              resp_valid,
    output logic [PA_W-1:0]   resp_paddr,
    output logic [PERM_W-1:0] resp_perm,
    output logic              resp_translated,
    output logic              fault_req,
    output logic [VA_W-1:0]   fault_addr,
    output logic [CODE_W-1:0] fault_code,
    output logic              recur_err
);
    typedef struct packed {
        logic              rvalid;
        logic [PA_W-1:0]   paddr;
        logic [PERM_W-1:0] perm;
        logic              xlated;
        logic              freq;
        logic [VA_W-1:0]   faddr;
        logic [CODE_W-1:0] fcode;
        logic              pending;
        logic              recur;
    } state_t;

    state_t    st_d, st_q;
    decision_e decision;
    logic [PA_W-1:0]   map_pa, byp_pa;
    logic [CODE_W-1:0] new_code;
    logic              is_fault;

    xlate_fault_classify u_cls (
        .req_valid (req_valid),
        .mmu_fitted(mmu_fitted),
        .xlate_en  (xlate_en),
        .tlb_hit   (tlb_hit),
        .tlb_prot  (tlb_prot),
        .decision  (decision)
    );

    xlate_fault_addr #(
        .VA_W      (VA_W),
        .PA_W      (PA_W),
        .PAGE_BYTES(PAGE_BYTES)
    ) u_addr (
        .vaddr       (req_vaddr),
        .vbase       (tlb_vbase),
        .pbase       (tlb_pbase),
        .mapped_paddr(map_pa),
        .bypass_paddr(byp_pa)
    );

    xlate_fault_code #(
        .CODE_W(CODE_W)
    ) u_code (
        .is_prot (decision == DEC_PROT),
        .acc_type(req_type),
        .code    (new_code)
    );

    assign is_fault = (decision == DEC_MISS) || (decision == DEC_PROT);

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = 1'b0;
        st_d.freq   = 1'b0;
        st_d.recur  = 1'b0;
        if (fault_ack) begin
            st_d.pending = 1'b0;
        end
        case (decision)
            DEC_BYPASS: begin
                st_d.rvalid = 1'b1;
                st_d.paddr  = byp_pa;
                st_d.perm   = '1;
                st_d.xlated = 1'b0;
            end
            DEC_MAP: begin
                st_d.rvalid = 1'b1;
                st_d.paddr  = map_pa;
                st_d.perm   = tlb_perm;
                st_d.xlated = 1'b1;
            end
            default: ;
        endcase
        if (is_fault) begin
            if (st_q.pending && !fault_ack) begin
                st_d.recur = 1'b1;
            end else begin
                st_d.freq    = 1'b1;
                st_d.faddr   = req_vaddr;
                st_d.fcode   = new_code;
                st_d.pending = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign resp_valid      = st_q.rvalid;
    assign resp_paddr      = st_q.paddr;
    assign resp_perm       = st_q.perm;
    assign resp_translated = st_q.xlated;
    assign fault_req       = st_q.freq;
    assign fault_addr      = st_q.faddr;
    assign fault_code      = st_q.fcode;
    assign recur_err       = st_q.recur;
endmodule

// File: rtl/xlate_fault_checker.sv
module xlate_fault_checker #(
    parameter int unsigned VA_W       = 32,
    parameter int unsigned PA_W       = 32,
    parameter int unsigned PERM_W     = 3,
    parameter int unsigned CODE_W     = 16,
    parameter int unsigned PAGE_BYTES = 4096
) (
    input logic              clk,
    input logic              rst_n,
    input logic              resp_valid,
    input logic [PA_W-1:0]   resp_paddr,
    input logic [PERM_W-1:0] resp_perm,
    input logic              resp_translated,
    input logic              fault_req,
    input logic [VA_W-1:0]   fault_addr,
    input logic [CODE_W-1:0] fault_code,
    input logic              recur_err
);
    localparam int unsigned OFS_W = $clog2(PAGE_BYTES);

    p_bypass_full_perm_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_translated) |->
            (resp_perm == '1 && resp_paddr[OFS_W-1:0] == '0));

    p_code_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fault_req |-> (fault_code[4:0] >= 5'd16 && fault_code[4:0] <= 5'd19));

    p_no_resp_on_fault_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({resp_valid, fault_req, recur_err}));

    p_hold_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_req |-> ($stable(fault_addr) && $stable(fault_code)));

    p_recursive_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        recur_err |-> (!fault_req && $stable(fault_addr) && $stable(fault_code)));
endmodule

bind xlate_fault_unit xlate_fault_checker #(
    .VA_W      (VA_W),
    .PA_W      (PA_W),
    .PERM_W    (PERM_W),
    .CODE_W    (CODE_W),
    .PAGE_BYTES(PAGE_BYTES)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .resp_valid     (resp_valid),
    .resp_paddr     (resp_paddr),
    .resp_perm      (resp_perm),
    .resp_translated(resp_translated),
    .fault_req      (fault_req),
    .fault_addr     (fault_addr),
    .fault_code     (fault_code),
    .recur_err      (recur_err)
);

// File: tb/sim_xlate_fault_unit.sv
`timescale 1ns/1ps
module sim_xlate_fault_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_type = 2'd0;
    logic [31:0] req_vaddr = '0;
    logic        mmu_fitted = 1'b0;
    logic        xlate_en = 1'b0;
    logic        tlb_hit = 1'b0;
    logic        tlb_prot = 1'b0;
    logic [31:0] tlb_vbase = '0;
    logic [31:0] tlb_pbase = '0;
    logic [2:0]  tlb_perm = '0;
    logic        fault_ack = 1'b0;
    logic        resp_valid;
    logic [31:0] resp_paddr;
    logic [2:0]  resp_perm;
    logic        resp_translated;
    logic        fault_req;
    logic [31:0] fault_addr;
    logic [15:0] fault_code;
    logic        recur_err;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    typedef struct {
        logic        rv;
        logic [31:0] pa;
        logic [2:0]  perm;
        logic        tr;
        logic        fr;
        logic [31:0] fa;
        logic [15:0] fc;
        logic        rec;
        string       tag;
    } exp_t;

    exp_t exp_q[$];

    logic [31:0] m_fa = '0;
    logic [15:0] m_fc = '0;
    bit          m_pend = 1'b0;

    always #2 clk = ~clk;

    xlate_fault_unit u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_type(req_type),
        .req_vaddr(req_vaddr), .mmu_fitted(mmu_fitted), .xlate_en(xlate_en),
        .tlb_hit(tlb_hit), .tlb_prot(tlb_prot), .tlb_vbase(tlb_vbase),
        .tlb_pbase(tlb_pbase), .tlb_perm(tlb_perm), .fault_ack(fault_ack),
        .resp_valid(resp_valid), .resp_paddr(resp_paddr), .resp_perm(resp_perm),
        .resp_translated(resp_translated), .fault_req(fault_req),
        .fault_addr(fault_addr), .fault_code(fault_code), .recur_err(recur_err)
    );

    task automatic step(input logic v, input logic [1:0] ty, input logic [31:0] va,
                        input logic fit, input logic xe, input logic hit,
                        input logic prot, input logic [31:0] vb, input logic [31:0] pb,
                        input logic [2:0] pm, input logic ack, input string tag);
        exp_t e;
        @(negedge clk);
        req_valid = v; req_type = ty; req_vaddr = va; mmu_fitted = fit;
        xlate_en = xe; tlb_hit = hit; tlb_prot = prot; tlb_vbase = vb;
        tlb_pbase = pb; tlb_perm = pm; fault_ack = ack;
        e.rv = 1'b0; e.pa = '0; e.perm = '0; e.tr = 1'b0;
        e.fr = 1'b0; e.rec = 1'b0; e.tag = tag;
        if (ack) m_pend = 1'b0;
        if (v && !(fit && xe)) begin
            e.rv = 1'b1; e.pa = va & 32'hFFFF_F000; e.perm = 3'b111;
        end else if (v && hit) begin
            e.rv = 1'b1; e.pa = pb + (va & 32'hFFFF_F000) - vb; e.perm = pm; e.tr = 1'b1;
        end else if (v) begin
            if (m_pend) begin
                e.rec = 1'b1;
            end else begin
                e.fr = 1'b1; m_pend = 1'b1; m_fa = va;
                m_fc = '0;
                m_fc[4:0] = prot ? ((ty == 2'd2) ? 5'd17 : 5'd16)
                                 : ((ty == 2'd2) ? 5'd19 : 5'd18);
                m_fc[10] = (ty == 2'd1);
            end
        end
        e.fa = m_fa; e.fc = m_fc;
        exp_q.push_back(e);
    endtask

    task automatic idle(input string tag);
        step(1'b0, 2'd0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, '0, '0, '0, 1'b0, tag);
    endtask

    // Monitor: compares each registered result one clock after its request
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            exp_t e;
            bit bad;
            e = exp_q.pop_front();
            bad = (resp_valid !== e.rv) || (fault_req !== e.fr) || (recur_err !== e.rec)
               || (fault_addr !== e.fa) || (fault_code !== e.fc);
            if (e.rv && ((resp_paddr !== e.pa) || (resp_perm !== e.perm)
                         || (resp_translated !== e.tr)))
                bad = 1'b1;
            n_tests++;
            if (bad) begin
                n_fail++;
                $display("FAIL %s: got rv=%b pa=%h perm=%b tr=%b fr=%b fa=%h fc=%h rec=%b exp rv=%b pa=%h perm=%b tr=%b fr=%b fa=%h fc=%h rec=%b",
                    e.tag, resp_valid, resp_paddr, resp_perm, resp_translated, fault_req,
                    fault_addr, fault_code, recur_err, e.rv, e.pa, e.perm, e.tr, e.fr,
                    e.fa, e.fc, e.rec);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        n_tests++;
        if (resp_valid !== 1'b0 || fault_req !== 1'b0 || recur_err !== 1'b0 ||
            fault_addr !== '0 || fault_code !== '0) begin
            n_fail++;
            $display("FAIL R1: got rv=%b fr=%b rec=%b fa=%h fc=%h exp all zero",
                     resp_valid, fault_req, recur_err, fault_addr, fault_code);
        end
        rst_n = 1'b1;
        // R2: bypass, unit not fitted; TLB inputs carry garbage and must be ignored
        step(1, 2'd0, 32'h1234_5678, 0, 1, 1, 1, 32'h1234_5000, 32'hAAAA_0000, 3'b001, 0, "R2 not fitted");
        // R2: bypass, translation disabled
        step(1, 2'd2, 32'hFFFF_FFFF, 1, 0, 0, 1, '0, '0, 3'b000, 0, "R2 disabled");
        // R3: mapped hits
        step(1, 2'd0, 32'h0000_3ABC, 1, 1, 1, 0, 32'h0000_3000, 32'h8000_0000, 3'b101, 0, "R3 hit a");
        step(1, 2'd1, 32'h0041_2FFF, 1, 1, 1, 0, 32'h0040_0000, 32'h1000_0000, 3'b011, 0, "R3 hit b");
        // R6 R4: load miss
        step(1, 2'd0, 32'hDEAD_BEEF, 1, 1, 0, 0, '0, '0, '0, 0, "R6 R4 load miss");
        // R9: idle, values held
        idle("R9 hold a");
        idle("R9 hold b");
        // R5: fetch protection, ack arrives together (R11)
        step(1, 2'd2, 32'h0000_1004, 1, 1, 0, 1, '0, '0, '0, 1, "R5 R11 fetch prot");
        // R5 R7: store protection
        step(1, 2'd1, 32'h7777_0010, 1, 1, 0, 1, '0, '0, '0, 1, "R5 R7 store prot");
        step(0, 2'd0, 32'h0, 0, 0, 0, 0, '0, '0, '0, 1, "R9 ack only");
        // R6: fetch miss, then store miss (R7)
        step(1, 2'd2, 32'h0000_2220, 1, 1, 0, 0, '0, '0, '0, 0, "R6 fetch miss");
        idle("R9 pending hold");
        // R10: recursive fault while pending
        step(1, 2'd1, 32'h5555_5555, 1, 1, 0, 0, '0, '0, '0, 0, "R10 recursive");
        idle("R10 state kept");
        // R11: ack in same cycle as new store miss
        step(1, 2'd1, 32'h6666_6666, 1, 1, 0, 0, '0, '0, '0, 1, "R11 R7 store miss");
        // R7: reserved type treated as load, protection
        step(1, 2'd3, 32'h0BAD_0000, 1, 1, 0, 1, '0, '0, '0, 1, "R7 type3");
        // R10: again without ack, then an unaffected bypass
        step(1, 2'd0, 32'h0123_4567, 1, 1, 0, 1, '0, '0, '0, 0, "R10 recursive b");
        step(1, 2'd0, 32'h0000_0FFF, 1, 0, 0, 0, '0, '0, '0, 0, "R2 page zero");
        idle("R9 end");
        idle("R9 end");
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
                @(negedge clk);
            end
            begin
                repeat (5000) @(posedge clk);
                n_tests++;
                n_fail++;
                $display("FAIL watchdog: got timeout exp completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule